// File: doc/BRIEF.md
# Event Frame Generator with Double-Buffered Sequencer

This block builds the parallel word that a timing transmitter sends to its receivers, one word per clock. Each 16-bit frame has two halves. The lower byte holds one 8-bit event code, and code 0 means "no event". The upper byte carries eight free-running clock bits taken from a parallel input and delayed to line up with the code. Event codes come from three kinds of source: eight external trigger lines, a host register write, and two sequence memories that replay stored event lists.

A single start pulse launches playback of one sequence memory. Each stored entry then goes out on a step. A step happens on every N-th pulse of an external revolution tick, and N is set by the host. In alternate mode the playing memory changes to the other one at each start. This lets the host refill one memory while the other plays. When more than one source wants the same frame, a fixed priority picks the winner. A source that loses keeps its request and sends on a later frame.

Top module: `evg_frame_top`

## Requirements
- R1: While reset is asserted, `frame`, `frame_vld` and `wr_err` are 0. From the first clock after reset, `frame_vld` is 1 and a new frame is registered every clock. `frame[15:8]` equals the `clk_bits` value sampled at the same edge that produces the frame.
- R2: When no request is pending and no sequence step fires, `frame[7:0]` is 0.
- R3: A rising edge on `hw_trig[i]` queues the code held in host register address i (0..7). That code appears in the frame two clocks after the edge if nothing outranks it. A line held high queues only once.
- R4: A host write to address 8 queues `cfg_wdata` as a software event. It appears two clocks after the write if nothing outranks it.
- R5: The priority order is sequence step, then trigger inputs with the lowest index first, then software. Only one code goes out per frame. Every losing request stays pending and is sent later, and none is dropped.
- R6: A `seq_start` pulse while playback is idle begins playback at entry 0. A start pulse during playback is ignored.
- R7: Address 9 holds the step multiple N, and a value of 0 acts as 1. During playback, every N-th `rev_tick` pulse emits the current entry's code one clock after that tick.
- R8: A memory entry is {bit 8 = end flag, bits 7:0 = code}. The entry with the end flag set is emitted, then playback becomes idle. The next playback starts again from entry 0.
- R9: Memory 0 is selected after reset. A start with `alt_mode` = 1 switches playback to the other memory. A start with `alt_mode` = 0 replays the memory used last.
- R10: A host memory write aimed at the memory that is playing is discarded. It sets `wr_err`, which stays 1 until reset. Writes to the other memory take effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Frame clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_trig | input | 8 | External trigger lines, edge-detected |
| cfg_wr | input | 1 | Host register write strobe |
| cfg_addr | input | 4 | Register address: 0..7 trigger codes, 8 software event, 9 step multiple |
| cfg_wdata | input | 8 | Register write data |
| ram_wr | input | 1 | Sequence memory write strobe |
| ram_sel | input | 1 | Selects which memory is written |
| ram_addr | input | 8 | Memory entry address |
| ram_wdata | input | 9 | Entry data {end flag, code} |
| seq_start | input | 1 | Playback start pulse |
| alt_mode | input | 1 | Swap memories on each start |
| rev_tick | input | 1 | Revolution-period tick pulse |
| clk_bits | input | 8 | Clock bits for the frame's upper byte |
| frame | output | 16 | Registered frame {clock bits, event code} |
| frame_vld | output | 1 | Frame valid strobe |
| wr_err | output | 1 | Sticky flag for rejected memory writes |

## Verification
Faults in the step counter or read pointer show up as a code that arrives on the wrong `rev_tick`, or as a skipped or repeated entry. Either one is visible in the first frame after the faulty tick. A wrong memory-select bit makes the other memory's codes appear on the first step after a start. This error is also how a write that should have been rejected is exposed: it surfaces when that memory is played again. Lost or duplicated pending bits in the trigger and software paths change the order or the count of codes within a few frames. A scoreboard that matches every nonzero code against the expected order catches these faults, and it also catches codes left over at the end of the test.

// File: rtl/evg_pkg.sv
package evg_pkg;
  localparam int unsigned EVG_CODE_W = 8;

  // One stored sequence entry: end marker above the event code.
  typedef struct packed {
    logic                  last;
    logic [EVG_CODE_W-1:0] code;
  } seq_entry_t;
endpackage

// File: rtl/evg_src_regs.sv
module evg_src_regs #(
  parameter int unsigned N_HW   = 8,
  parameter int unsigned CODE_W = 8,
  parameter int unsigned CFG_AW = 4
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [N_HW-1:0]               hw_trig,
  input  logic                          cfg_wr,
  input  logic [CFG_AW-1:0]             cfg_addr,
  input  logic [CODE_W-1:0]             cfg_wdata,
  input  logic [N_HW-1:0]               hw_grant,
  input  logic                          sw_grant,
  output logic [N_HW-1:0]               hw_req,
  output logic [N_HW-1:0][CODE_W-1:0]   hw_code,
  output logic                          sw_req,
  output logic [CODE_W-1:0]             sw_code,
  output logic [CODE_W-1:0]             step_mult
);
  localparam logic [CFG_AW-1:0] SW_ADDR   = CFG_AW'(N_HW);
  localparam logic [CFG_AW-1:0] STEP_ADDR = CFG_AW'(N_HW + 1);

  logic [N_HW-1:0]             trig_q_r;
  logic [N_HW-1:0]             pend_r, pend_n;
  logic [N_HW-1:0][CODE_W-1:0] map_r;
  logic                        sw_pend_r, sw_pend_n;
  logic [CODE_W-1:0]           sw_code_r;
  logic [CODE_W-1:0]           step_r;
  logic                        sw_wr;

  assign sw_wr = cfg_wr && (cfg_addr == SW_ADDR);

  always_comb begin
    for (int i = 0; i < N_HW; i++) begin
      pend_n[i] = (hw_trig[i] && !trig_q_r[i]) || (pend_r[i] && !hw_grant[i]);
    end
    sw_pend_n = sw_wr || (sw_pend_r && !sw_grant);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trig_q_r  <= '0;
      pend_r    <= '0;
      map_r     <= '0;
      sw_pend_r <= 1'b0;
      sw_code_r <= '0;
      step_r    <= '0;
    end else begin
      trig_q_r  <= hw_trig;
      pend_r    <= pend_n;
      sw_pend_r <= sw_pend_n;
      for (int i = 0; i < N_HW; i++) begin
        if (cfg_wr && (cfg_addr == CFG_AW'(i))) map_r[i] <= cfg_wdata;
      end
      if (sw_wr) sw_code_r <= cfg_wdata;
      if (cfg_wr && (cfg_addr == STEP_ADDR)) step_r <= cfg_wdata;
    end
  end

  assign hw_req    = pend_r;
  assign hw_code   = map_r;
  assign sw_req    = sw_pend_r;
  assign sw_code   = sw_code_r;
  assign step_mult = step_r;

  // R3: a rising trigger edge always leaves a pending request
  a_r3_edge_pends: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_trig[0] && !trig_q_r[0]) |=> hw_req[0]);
  // R5: an ungranted trigger request is kept
  a_r5_hw_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (hw_req[N_HW-1] && !hw_grant[N_HW-1]) |=> hw_req[N_HW-1]);
  // R4: a software write always leaves a pending request
  a_r4_sw_pends: assert property (@(posedge clk) disable iff (!rst_n)
    sw_wr |=> sw_req);
endmodule

// File: rtl/evg_seq_player.sv
module evg_seq_player
  import evg_pkg::*;
#(
  parameter int unsigned DEPTH  = 256,
  parameter int unsigned CODE_W = 8,
  localparam int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ram_wr,
  input  logic              ram_sel,
  input  logic [AW-1:0]     ram_addr,
  input  logic [CODE_W:0]   ram_wdata,
  input  logic              seq_start,
  input  logic              alt_mode,
  input  logic              rev_tick,
  input  logic [CODE_W-1:0] step_mult,
  output logic              seq_vld,
  output logic [CODE_W-1:0] seq_code,
  output logic              wr_err
);
  logic              busy_r, busy_n;
  logic              bank_r, bank_n;
  logic [AW-1:0]     addr_r, addr_n;
  logic [CODE_W-1:0] div_r, div_n;
  logic              err_r, err_n;
  logic [CODE_W-1:0] step_lim;
  logic              step_hit;
  logic              wr_block;
  logic [CODE_W:0]   bank_rd [2];
  seq_entry_t        cur;

  assign wr_block = busy_r && (ram_sel == bank_r);

  for (genvar g = 0; g < 2; g++) begin : g_bank
    logic [CODE_W:0] mem [DEPTH];
    always_ff @(posedge clk) begin
      if (ram_wr && (ram_sel == g[0]) && !wr_block) mem[ram_addr] <= ram_wdata;
    end
    assign bank_rd[g] = mem[addr_r];
  end

  assign cur      = seq_entry_t'(bank_rd[bank_r]);
  assign step_lim = (step_mult == '0) ? '0 : step_mult - 1'b1;
  assign step_hit = busy_r && rev_tick && (div_r == step_lim);

  always_comb begin
    busy_n = busy_r;
    bank_n = bank_r;
    addr_n = addr_r;
    div_n  = div_r;
    err_n  = err_r || (ram_wr && wr_block);
    if (seq_start && !busy_r) begin
      busy_n = 1'b1;
      bank_n = alt_mode ? ~bank_r : bank_r;
      addr_n = '0;
      div_n  = '0;
    end else if (busy_r && rev_tick) begin
      if (step_hit) begin
        div_n  = '0;
        addr_n = addr_r + 1'b1;
        if (cur.last) busy_n = 1'b0;
      end else begin
        div_n = div_r + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_r <= 1'b0;
      bank_r <= 1'b0;
      addr_r <= '0;
      div_r  <= '0;
      err_r  <= 1'b0;
    end else begin
      busy_r <= busy_n;
      bank_r <= bank_n;
      addr_r <= addr_n;
      div_r  <= div_n;
      err_r  <= err_n;
    end
  end

  assign seq_vld  = step_hit;
  assign seq_code = cur.code;
  assign wr_err   = err_r;

  // R8: an end-flagged entry finishes playback
  a_r8_end_idles: assert property (@(posedge clk) disable iff (!rst_n)
    (seq_vld && cur.last) |=> !busy_r);
  // R9: the playing memory changes only on an accepted start
  a_r9_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !(seq_start && !busy_r) |=> $stable(bank_r));
  // R6: a start during playback leaves the read pointer moving only by steps
  a_r6_busy_start: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_r && seq_start && !rev_tick) |=> $stable(addr_r));
  // R10: a rejected write raises the flag, which then stays set
  a_r10_reject_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_wr && busy_r && (ram_sel == bank_r)) |=> wr_err);
  a_r10_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> wr_err);
endmodule

// File: rtl/evg_arbiter.sv
module evg_arbiter #(
  parameter int unsigned N_HW   = 8,
  parameter int unsigned CODE_W = 8
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        seq_vld,
  input  logic [CODE_W-1:0]           seq_code,
  input  logic [N_HW-1:0]             hw_req,
  input  logic [N_HW-1:0][CODE_W-1:0] hw_code,
  input  logic                        sw_req,
  input  logic [CODE_W-1:0]           sw_code,
  output logic [N_HW-1:0]             hw_grant,
  output logic                        sw_grant,
  output logic [CODE_W-1:0]           win_code
);
  logic taken;

  always_comb begin
    win_code = '0;
    hw_grant = '0;
    sw_grant = 1'b0;
    taken    = 1'b0;
    if (seq_vld) begin
      win_code = seq_code;
      taken    = 1'b1;
    end
    for (int i = 0; i < N_HW; i++) begin
      if (!taken && hw_req[i]) begin
        hw_grant[i] = 1'b1;
        win_code    = hw_code[i];
        taken       = 1'b1;
      end
    end
    if (!taken && sw_req) begin
      sw_grant = 1'b1;
      win_code = sw_code;
    end
  end

  // R5: a sequence step blocks every other grant
  a_r5_seq_first: assert property (@(posedge clk) disable iff (!rst_n)
    seq_vld |-> (hw_grant == '0) && !sw_grant);
  // R5: software waits while any trigger is pending
  a_r5_sw_last: assert property (@(posedge clk) disable iff (!rst_n)
    (|hw_req) |-> !sw_grant);
  // R5: at most one source granted per frame
  a_r5_single: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({hw_grant, sw_grant}));
endmodule

// File: rtl/evg_frame_top.sv
module evg_frame_top #(
  parameter int unsigned N_HW   = 8,
  parameter int unsigned CODE_W = 8,
  parameter int unsigned CLKB_W = 8,
  parameter int unsigned DEPTH  = 256,
  localparam int unsigned AW     = $clog2(DEPTH),
  localparam int unsigned CFG_AW = $clog2(N_HW) + 1,
  localparam int unsigned FRM_W  = CLKB_W + CODE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_HW-1:0]   hw_trig,
  input  logic              cfg_wr,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [CODE_W-1:0] cfg_wdata,
  input  logic              ram_wr,
  input  logic              ram_sel,
  input  logic [AW-1:0]     ram_addr,
  input  logic [CODE_W:0]   ram_wdata,
  input  logic              seq_start,
  input  logic              alt_mode,
  input  logic              rev_tick,
  input  logic [CLKB_W-1:0] clk_bits,
  output logic [FRM_W-1:0]  frame,
  output logic              frame_vld,
  output logic              wr_err
);
  logic [N_HW-1:0]             hw_req, hw_grant;
  logic [N_HW-1:0][CODE_W-1:0] hw_code;
  logic                        sw_req, sw_grant;
  logic [CODE_W-1:0]           sw_code, step_mult, seq_code, win_code;
  logic                        seq_vld;
  logic [FRM_W-1:0]            frame_r, frame_n;
  logic                        vld_r;

  evg_src_regs #(.N_HW(N_HW), .CODE_W(CODE_W), .CFG_AW(CFG_AW)) u_src (
    .clk, .rst_n, .hw_trig, .cfg_wr, .cfg_addr, .cfg_wdata,
    .hw_grant, .sw_grant, .hw_req, .hw_code, .sw_req, .sw_code, .step_mult
  );

  evg_seq_player #(.DEPTH(DEPTH), .CODE_W(CODE_W)) u_seq (
    .clk, .rst_n, .ram_wr, .ram_sel, .ram_addr, .ram_wdata, .seq_start,
    .alt_mode, .rev_tick, .step_mult, .seq_vld, .seq_code, .wr_err
  );

  evg_arbiter #(.N_HW(N_HW), .CODE_W(CODE_W)) u_arb (
    .clk, .rst_n, .seq_vld, .seq_code, .hw_req, .hw_code, .sw_req, .sw_code,
    .hw_grant, .sw_grant, .win_code
  );

  assign frame_n = {clk_bits, win_code};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_r <= '0;
      vld_r   <= 1'b0;
    end else begin
      frame_r <= frame_n;
      vld_r   <= 1'b1;
    end
  end

  assign frame     = frame_r;
  assign frame_vld = vld_r;

  // R2: an idle cycle yields the null code
  a_r2_null_code: assert property (@(posedge clk) disable iff (!rst_n)
    (!seq_vld && (hw_req == '0) && !sw_req) |=> (frame[CODE_W-1:0] == '0));
  // R1: clock bits pass to the upper byte one edge later
  a_r1_clock_bits: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (frame[FRM_W-1:CODE_W] == $past(clk_bits)));
endmodule

// File: tb/evg_frame_top_tb_top.sv
`timescale 1ns/1ps
module evg_frame_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [7:0]  hw_trig;
  logic        cfg_wr;
  logic [3:0]  cfg_addr;
  logic [7:0]  cfg_wdata;
  logic        ram_wr, ram_sel;
  logic [7:0]  ram_addr;
  logic [8:0]  ram_wdata;
  logic        seq_start, alt_mode, rev_tick;
  logic [7:0]  clk_bits;
  logic [15:0] frame;
  logic        frame_vld, wr_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [7:0] exp_q[$];
  logic [7:0] cb_drv = 8'h00;

  always #2.5 clk = ~clk;

  evg_frame_top dut_i (
    .clk, .rst_n, .hw_trig, .cfg_wr, .cfg_addr, .cfg_wdata, .ram_wr, .ram_sel,
    .ram_addr, .ram_wdata, .seq_start, .alt_mode, .rev_tick, .clk_bits,
    .frame, .frame_vld, .wr_err
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  // Monitor: clock-bit alignment (R1) and scoreboard of event codes (R5)
  always @(negedge clk) begin
    if (rst_n && frame_vld) begin
      chk("R1 clock bits", {8'h00, frame[15:8]}, {8'h00, cb_drv});
      if (frame[7:0] != 8'h00) begin
        if (exp_q.size() == 0) chk("R5 unexpected code", {8'h00, frame[7:0]}, 16'h0000);
        else chk("R5 code order", {8'h00, frame[7:0]}, {8'h00, exp_q.pop_front()});
      end
    end
    cb_drv   = cb_drv + 8'd37;
    clk_bits = cb_drv;
  end

  task automatic cfg_write(input logic [3:0] a, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic ram_write(input logic s, input logic [7:0] a, input logic [7:0] c, input logic last);
    @(negedge clk); ram_wr = 1'b1; ram_sel = s; ram_addr = a; ram_wdata = {last, c};
    @(negedge clk); ram_wr = 1'b0;
  endtask

  task automatic start_seq(input logic alt);
    @(negedge clk); alt_mode = alt; seq_start = 1'b1;
    @(negedge clk); seq_start = 1'b0;
  endtask

  task automatic tick(output logic [7:0] seen);
    @(negedge clk); rev_tick = 1'b1;
    @(negedge clk); rev_tick = 1'b0; seen = frame[7:0];
  endtask

  task automatic step_expect(input string req, input logic [7:0] code);
    logic [7:0] seen;
    exp_q.push_back(code);
    tick(seen);
    chk(req, {8'h00, seen}, {8'h00, code});
  endtask

  task automatic step_none(input string req);
    logic [7:0] seen;
    tick(seen);
    chk(req, {8'h00, seen}, 16'h0000);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; hw_trig = '0; cfg_wr = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    ram_wr = 1'b0; ram_sel = 1'b0; ram_addr = '0; ram_wdata = '0;
    seq_start = 1'b0; alt_mode = 1'b0; rev_tick = 1'b0; clk_bits = '0;
    repeat (3) @(negedge clk);
    chk("R1 reset frame", frame, 16'h0000);
    chk("R1 reset valid", {15'h0, frame_vld}, 16'h0000);
    chk("R1 reset error flag", {15'h0, wr_err}, 16'h0000);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 valid after reset", {15'h0, frame_vld}, 16'h0001);
    chk("R2 null code idle", {8'h00, frame[7:0]}, 16'h0000);

    for (int i = 0; i < 8; i++) cfg_write(4'(i), 8'hA0 + 8'(i));

    // R3: held trigger queues once, two clocks after the edge
    @(negedge clk); hw_trig[2] = 1'b1; exp_q.push_back(8'hA2);
    @(negedge clk);
    @(negedge clk); chk("R3 trigger code", {8'h00, frame[7:0]}, 16'h00A2);
    repeat (4) @(negedge clk);
    chk("R3 held line no repeat", {8'h00, frame[7:0]}, 16'h0000);
    hw_trig[2] = 1'b0;

    // R4: software event
    exp_q.push_back(8'h55);
    cfg_write(4'd8, 8'h55);
    @(negedge clk); chk("R4 software code", {8'h00, frame[7:0]}, 16'h0055);

    // Load both memories
    ram_write(1'b0, 8'd0, 8'h31, 1'b0);
    ram_write(1'b0, 8'd1, 8'h32, 1'b0);
    ram_write(1'b0, 8'd2, 8'h33, 1'b1);
    ram_write(1'b1, 8'd0, 8'h41, 1'b0);
    ram_write(1'b1, 8'd1, 8'h42, 1'b1);

    // R7: step multiple 3, memory 0 after reset (R9)
    cfg_write(4'd9, 8'd3);
    start_seq(1'b0);
    step_none("R7 tick 1 of 3");
    step_none("R7 tick 2 of 3");
    step_expect("R7 R9 third tick memory 0", 8'h31);
    step_none("R7 tick 1 of 3 second step");
    step_none("R7 tick 2 of 3 second step");
    step_expect("R7 second step", 8'h32);
    step_none("R7 tick 1 of 3 third step");
    step_none("R7 tick 2 of 3 third step");
    step_expect("R8 end entry emitted", 8'h33);
    repeat (3) step_none("R8 idle after end");

    // R7: multiple 0 acts as 1; R9 non-alternate replays memory 0 from entry 0
    cfg_write(4'd9, 8'd0);
    start_seq(1'b0);
    step_expect("R9 replay same memory", 8'h31);
    step_expect("R7 every tick", 8'h32);
    step_expect("R8 end again", 8'h33);
    step_none("R8 idle");

    // R9 alternate: switch to memory 1; R10 write to playing memory rejected
    start_seq(1'b1);
    ram_write(1'b1, 8'd0, 8'h99, 1'b0);
    chk("R10 error flag set", {15'h0, wr_err}, 16'h0001);
    ram_write(1'b0, 8'd1, 8'h3A, 1'b0);
    step_expect("R9 alternate memory 1", 8'h41);
    step_expect("R9 memory 1 end", 8'h42);
    step_none("R8 idle after memory 1");

    // R9 swap back; R6 start during playback ignored
    start_seq(1'b1);
    step_expect("R9 back to memory 0", 8'h31);
    start_seq(1'b1);
    step_expect("R6 start ignored, R10 other memory written", 8'h3A);
    step_expect("R6 playback continues", 8'h33);
    start_seq(1'b1);
    step_expect("R10 rejected write left entry", 8'h41);
    step_expect("R10 memory 1 end", 8'h42);
    chk("R10 error flag sticky", {15'h0, wr_err}, 16'h0001);

    // R5: priority with all sources in the same frames
    start_seq(1'b0);
    @(negedge clk);
    hw_trig = 8'b0000_1001; cfg_wr = 1'b1; cfg_addr = 4'd8; cfg_wdata = 8'h66;
    exp_q.push_back(8'h41); exp_q.push_back(8'hA0);
    exp_q.push_back(8'hA3); exp_q.push_back(8'h66);
    @(negedge clk); hw_trig = '0; cfg_wr = 1'b0; rev_tick = 1'b1;
    @(negedge clk); rev_tick = 1'b0;
    chk("R5 sequence wins", {8'h00, frame[7:0]}, 16'h0041);
    @(negedge clk); chk("R5 lowest trigger next", {8'h00, frame[7:0]}, 16'h00A0);
    @(negedge clk); chk("R5 higher trigger next", {8'h00, frame[7:0]}, 16'h00A3);
    @(negedge clk); chk("R5 software last", {8'h00, frame[7:0]}, 16'h0066);
    @(negedge clk); chk("R2 null after drain", {8'h00, frame[7:0]}, 16'h0000);
    step_expect("R5 sequence resumes", 8'h42);

    repeat (5) @(negedge clk);
    chk("R5 nothing left pending", 16'(exp_q.size()), 16'h0000);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule